// File: doc/BRIEF.md
# Sensor Register SPI Transfer Engine

This block copies the complete 256-bit configuration image of an image sensor to or from the chip over SPI. The image is 32 bytes. A host on a simple word-wide register port loads the outgoing bytes, starts a burst with a command write, and later collects the incoming bytes. Each burst moves all 256 bits without a break. Once a burst has begun, nothing the host does can cut it short or start a second one.

The SPI side runs on a 25 MHz clock that comes from the sensor. The host side runs on its own bus clock. The byte buffer sits between the two domains. It is built as two simple dual-port halves. The outgoing half is written by the host and read byte by byte by the serialiser. The incoming half is written byte by byte by the deserialiser and read by the host.

Start requests cross into the sensor domain as a toggle. The burst-complete acknowledge crosses back the same way. Each crossing passes through two synchroniser flops. SCLK runs at half the sensor clock and idles low. MOSI changes only while SCLK is low, and MISO is sampled just before each falling edge of SCLK. After power-up the sensor holds all zeros, so the host is expected to issue a write burst first.

Top module: `sreg_spi_engine`

## Requirements
- R1: After reset, the status word reads 0 (not busy, not done, not rejected). CSN is high, SCLK is low, and MOSI is low. While CSN is high, SCLK and MOSI stay low.
- R2: Every burst holds CSN low for exactly 256 rising SCLK edges in one unbroken stretch.
- R3: A write burst sends byte 0 first and byte 31 last, each byte most-significant bit first. Host word w, lane j (bits 8j+7 down to 8j) supplies byte 4w+j. MOSI never changes on a rising SCLK edge.
- R4: A read burst places the 256 MISO bits into bytes 0 to 31, each byte filled most-significant bit first. The host reads them back with the lane mapping of R3. MOSI is held at 0 throughout a read burst.
- R5: Word address 8 is the control and status word. Its read value has busy in bit 0, done in bit 1 and rejected in bit 2. Busy is 1 from an accepted start until the burst's acknowledge returns. Done is then set, and it is cleared by the next accepted start. Busy and done are never 1 together.
- R6: A start written while busy is ignored and sets rejected. Rejected stays set until the host writes the control word with bit 2 set.
- R7: In a control write, bit 0 requests a write burst and bit 1 requests a read burst. When both bits are set, the engine starts a write burst.
- R8: Host writes to buffer words 0 to 7 while busy are ignored. The image being sent, and the stored image used by the next write burst, both stay unchanged.
- R9: A host read returns its data one clock after the read strobe. Addresses 9 to 15 read as 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| hst_clk | input | 1 | Host bus clock |
| hst_rst_n | input | 1 | Host domain reset, active low |
| hst_wr | input | 1 | Host write strobe |
| hst_rd | input | 1 | Host read strobe |
| hst_addr | input | 4 | Host word address |
| hst_wdata | input | 32 | Host write data |
| hst_rdata | output | 32 | Host read data, valid one cycle after hst_rd |
| sns_clk | input | 1 | 25 MHz clock from the sensor side |
| sns_rst_n | input | 1 | Sensor domain reset, active low |
| sns_sclk | output | 1 | SPI serial clock |
| sns_csn | output | 1 | SPI chip select, active low |
| sns_mosi | output | 1 | Serial data to the sensor |
| sns_miso | input | 1 | Serial data from the sensor |

## Verification
The hardest cases to reach are the ones that need host activity during the few thousand host cycles of a burst that is already running: a second start request, and a write into the outgoing buffer. The tasks issue these right after the start write, while the host-side busy view is already set but the sensor side is still shifting. The bench then checks the serial stream the slave model collected. It also runs a second write burst without reloading the buffer, which shows that the rejected buffer write never reached the stored image. The slave model counts SCLK rising edges per CSN window and serves its own image on MISO. This lets the bench check both directions, the bit order and the idle-low MOSI level of a read.

// File: rtl/sreg_pkg.sv
package sreg_pkg;
    localparam int SREG_BITS_DEF  = 256;
    localparam int SREG_HOST_W_DEF = 32;
    localparam int SREG_ADDR_W_DEF = 4;

    typedef enum logic [1:0] {
        SP_IDLE  = 2'd0,
        SP_SHIFT = 2'd1,
        SP_TAIL  = 2'd2
    } sp_state_e;
endpackage

// File: rtl/sreg_sync2.sv
module sreg_sync2 #(
    parameter int W = 1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] meta_q;
    logic [W-1:0] sync_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            meta_q <= '0;
            sync_q <= '0;
        end else begin
            meta_q <= d;
            sync_q <= meta_q;
        end
    end

    assign q = sync_q;
endmodule

// File: rtl/sreg_dpbuf.sv
module sreg_dpbuf #(
    parameter int NBYTES   = 32,
    parameter int WR_BYTES = 4,
    parameter int RD_BYTES = 1,
    localparam int IW  = $clog2(NBYTES),
    localparam int WAW = $clog2(NBYTES / WR_BYTES),
    localparam int RAW = $clog2(NBYTES / RD_BYTES)
) (
    input  logic                  wclk,
    input  logic                  we,
    input  logic [WAW-1:0]        waddr,
    input  logic [WR_BYTES*8-1:0] wdata,
    input  logic [RAW-1:0]        raddr,
    output logic [RD_BYTES*8-1:0] rdata
);
    logic [7:0] mem [NBYTES];

    always_ff @(posedge wclk) begin
        if (we) begin
            for (int j = 0; j < WR_BYTES; j++) begin
                mem[IW'(int'(waddr) * WR_BYTES + j)] <= wdata[8*j +: 8];
            end
        end
    end

    always_comb begin
        for (int j = 0; j < RD_BYTES; j++) begin
            rdata[8*j +: 8] = mem[IW'(int'(raddr) * RD_BYTES + j)];
        end
    end
endmodule

// File: rtl/sreg_host_ctl.sv
module sreg_host_ctl #(
    parameter int REG_BITS = 256,
    parameter int HOST_W   = 32,
    parameter int ADDR_W   = 4,
    localparam int NBYTES  = REG_BITS / 8,
    localparam int LANES   = HOST_W / 8,
    localparam int NWORDS  = NBYTES / LANES,
    localparam int WAW     = $clog2(NWORDS),
    localparam int CTRL_AD = NWORDS
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr,
    input  logic              rd,
    input  logic [ADDR_W-1:0] addr,
    input  logic [HOST_W-1:0] wdata,
    output logic [HOST_W-1:0] rdata,
    input  logic              ack_sync,
    output logic              req_tgl,
    output logic              op_rd,
    output logic              tx_we,
    output logic [WAW-1:0]    tx_waddr,
    output logic [HOST_W-1:0] tx_wdata,
    output logic [WAW-1:0]    rx_raddr,
    input  logic [HOST_W-1:0] rx_rdata,
    output logic              busy,
    output logic              done,
    output logic              rej
);
    typedef struct packed {
        logic              req;
        logic              op_rd;
        logic              ack_prev;
        logic              done;
        logic              rej;
        logic [HOST_W-1:0] rdata;
    } hst_regs_t;

    hst_regs_t q, d;
    logic is_buf, is_ctrl, go_wr, go_rd;

    always_comb begin
        busy    = (q.req != ack_sync);
        is_buf  = (addr < ADDR_W'(NWORDS));
        is_ctrl = (addr == ADDR_W'(CTRL_AD));
        go_wr   = wr && is_ctrl && wdata[0];
        go_rd   = wr && is_ctrl && wdata[1];

        d = q;
        d.ack_prev = ack_sync;
        if (ack_sync != q.ack_prev) begin
            d.done = 1'b1;
        end
        if (wr && is_ctrl && wdata[2]) begin
            d.rej = 1'b0;
        end
        if (go_wr || go_rd) begin
            if (busy) begin
                d.rej = 1'b1;
            end else begin
                d.req   = !q.req;
                d.op_rd = !go_wr;
                d.done  = 1'b0;
            end
        end

        d.rdata = '0;
        if (rd) begin
            if (is_buf) begin
                d.rdata = rx_rdata;
            end else if (is_ctrl) begin
                d.rdata = HOST_W'({q.rej, q.done, busy});
            end
        end

        tx_we    = wr && is_buf && !busy;
        tx_waddr = addr[WAW-1:0];
        tx_wdata = wdata;
        rx_raddr = addr[WAW-1:0];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '0;
        end else begin
            q <= d;
        end
    end

    assign rdata   = q.rdata;
    assign req_tgl = q.req;
    assign op_rd   = q.op_rd;
    assign done    = q.done;
    assign rej     = q.rej;
endmodule

// File: rtl/sreg_spi_fsm.sv
module sreg_spi_fsm
    import sreg_pkg::*;
#(
    parameter int REG_BITS = 256,
    localparam int BIT_CW  = $clog2(REG_BITS),
    localparam int BAW     = BIT_CW - 3
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           req_sync,
    input  logic           op_rd_in,
    output logic [BAW-1:0] tx_raddr,
    input  logic [7:0]     tx_rdata,
    output logic           rx_we,
    output logic [BAW-1:0] rx_waddr,
    output logic [7:0]     rx_wdata,
    output logic           ack_tgl,
    output logic           sclk,
    output logic           csn,
    output logic           mosi,
    input  logic           miso
);
    localparam logic [BIT_CW-1:0] LAST_BIT = BIT_CW'(REG_BITS - 1);

    typedef struct packed {
        sp_state_e         st;
        logic              req_seen;
        logic              op_rd;
        logic [BIT_CW-1:0] bit_cnt;
        logic [6:0]        sh;
        logic              sclk;
        logic              csn;
        logic              ack;
    } sp_regs_t;

    sp_regs_t q, d;

    always_comb begin
        d        = q;
        rx_we    = 1'b0;
        rx_wdata = {q.sh, miso};
        unique case (q.st)
            SP_IDLE: begin
                if (req_sync != q.req_seen) begin
                    d.req_seen = req_sync;
                    d.op_rd    = op_rd_in;
                    d.st       = SP_SHIFT;
                    d.csn      = 1'b0;
                    d.sclk     = 1'b0;
                    d.bit_cnt  = '0;
                end
            end
            SP_SHIFT: begin
                if (!q.sclk) begin
                    d.sclk = 1'b1;
                end else begin
                    d.sclk    = 1'b0;
                    d.sh      = {q.sh[5:0], miso};
                    rx_we     = q.op_rd && (q.bit_cnt[2:0] == 3'd7);
                    d.bit_cnt = q.bit_cnt + 1'b1;
                    if (q.bit_cnt == LAST_BIT) begin
                        d.st  = SP_TAIL;
                        d.csn = 1'b1;
                    end
                end
            end
            SP_TAIL: begin
                d.ack = !q.ack;
                d.st  = SP_IDLE;
            end
            default: d.st = SP_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q     <= '0;
            q.st  <= SP_IDLE;
            q.csn <= 1'b1;
        end else begin
            q <= d;
        end
    end

    assign tx_raddr = q.bit_cnt[BIT_CW-1:3];
    assign rx_waddr = q.bit_cnt[BIT_CW-1:3];
    assign ack_tgl  = q.ack;
    assign sclk     = q.sclk;
    assign csn      = q.csn;
    assign mosi     = (q.st == SP_SHIFT && !q.op_rd) ? tx_rdata[3'd7 - q.bit_cnt[2:0]] : 1'b0;
endmodule

// File: rtl/sreg_spi_engine.sv
module sreg_spi_engine
    import sreg_pkg::*;
#(
    parameter int REG_BITS = SREG_BITS_DEF,
    parameter int HOST_W   = SREG_HOST_W_DEF,
    parameter int ADDR_W   = SREG_ADDR_W_DEF,
    localparam int NBYTES  = REG_BITS / 8,
    localparam int LANES   = HOST_W / 8,
    localparam int WAW     = $clog2(NBYTES / LANES),
    localparam int BAW     = $clog2(NBYTES)
) (
    input  logic              hst_clk,
    input  logic              hst_rst_n,
    input  logic              hst_wr,
    input  logic              hst_rd,
    input  logic [ADDR_W-1:0] hst_addr,
    input  logic [HOST_W-1:0] hst_wdata,
    output logic [HOST_W-1:0] hst_rdata,
    input  logic              sns_clk,
    input  logic              sns_rst_n,
    output logic              sns_sclk,
    output logic              sns_csn,
    output logic              sns_mosi,
    input  logic              sns_miso
);
    logic              req_tgl, req_sync, op_rd, ack_tgl, ack_sync;
    logic              tx_we, rx_we;
    logic [WAW-1:0]    tx_waddr, rx_raddr;
    logic [HOST_W-1:0] tx_wdata, rx_rdata;
    logic [BAW-1:0]    tx_raddr, rx_waddr;
    logic [7:0]        tx_rdata, rx_wdata;
    logic              st_busy, st_done, st_rej;

    sreg_host_ctl #(.REG_BITS(REG_BITS), .HOST_W(HOST_W), .ADDR_W(ADDR_W)) u_host (
        .clk(hst_clk), .rst_n(hst_rst_n), .wr(hst_wr), .rd(hst_rd),
        .addr(hst_addr), .wdata(hst_wdata), .rdata(hst_rdata),
        .ack_sync(ack_sync), .req_tgl(req_tgl), .op_rd(op_rd),
        .tx_we(tx_we), .tx_waddr(tx_waddr), .tx_wdata(tx_wdata),
        .rx_raddr(rx_raddr), .rx_rdata(rx_rdata),
        .busy(st_busy), .done(st_done), .rej(st_rej)
    );

    sreg_sync2 #(.W(1)) u_req_sync (
        .clk(sns_clk), .rst_n(sns_rst_n), .d(req_tgl), .q(req_sync)
    );

    sreg_sync2 #(.W(1)) u_ack_sync (
        .clk(hst_clk), .rst_n(hst_rst_n), .d(ack_tgl), .q(ack_sync)
    );

    sreg_dpbuf #(.NBYTES(NBYTES), .WR_BYTES(LANES), .RD_BYTES(1)) u_txbuf (
        .wclk(hst_clk), .we(tx_we), .waddr(tx_waddr), .wdata(tx_wdata),
        .raddr(tx_raddr), .rdata(tx_rdata)
    );

    sreg_dpbuf #(.NBYTES(NBYTES), .WR_BYTES(1), .RD_BYTES(LANES)) u_rxbuf (
        .wclk(sns_clk), .we(rx_we), .waddr(rx_waddr), .wdata(rx_wdata),
        .raddr(rx_raddr), .rdata(rx_rdata)
    );

    sreg_spi_fsm #(.REG_BITS(REG_BITS)) u_spi (
        .clk(sns_clk), .rst_n(sns_rst_n), .req_sync(req_sync), .op_rd_in(op_rd),
        .tx_raddr(tx_raddr), .tx_rdata(tx_rdata),
        .rx_we(rx_we), .rx_waddr(rx_waddr), .rx_wdata(rx_wdata),
        .ack_tgl(ack_tgl), .sclk(sns_sclk), .csn(sns_csn),
        .mosi(sns_mosi), .miso(sns_miso)
    );
endmodule

// File: rtl/sreg_spi_engine_chk.sv
module sreg_spi_engine_chk #(
    parameter int REG_BITS = 256,
    parameter int HOST_W   = 32,
    parameter int ADDR_W   = 4,
    localparam int CTRL_AD = REG_BITS / HOST_W,
    localparam int CW      = $clog2(REG_BITS) + 1
) (
    input logic              hst_clk,
    input logic              hst_rst_n,
    input logic              hst_wr,
    input logic [ADDR_W-1:0] hst_addr,
    input logic [HOST_W-1:0] hst_wdata,
    input logic              sns_clk,
    input logic              sns_rst_n,
    input logic              sns_sclk,
    input logic              sns_csn,
    input logic              sns_mosi,
    input logic              st_busy,
    input logic              st_done,
    input logic              st_rej
);
    logic [CW-1:0] hi_cnt;
    logic          clr_rej;

    always_ff @(posedge sns_clk or negedge sns_rst_n) begin
        if (!sns_rst_n) begin
            hi_cnt <= '0;
        end else if (sns_csn) begin
            hi_cnt <= '0;
        end else begin
            hi_cnt <= hi_cnt + CW'(sns_sclk);
        end
    end

    assign clr_rej = hst_wr && (hst_addr == ADDR_W'(CTRL_AD)) && hst_wdata[2];

    AST_BURST_LEN: assert property (@(posedge sns_clk) disable iff (!sns_rst_n)
        $rose(sns_csn) |-> (hi_cnt == CW'(REG_BITS))); // R2
    AST_SCLK_PARKED: assert property (@(posedge sns_clk) disable iff (!sns_rst_n)
        sns_csn |-> !sns_sclk); // R1
    AST_MOSI_IDLE_LOW: assert property (@(posedge sns_clk) disable iff (!sns_rst_n)
        sns_csn |-> !sns_mosi); // R1
    AST_MOSI_SETTLED: assert property (@(posedge sns_clk) disable iff (!sns_rst_n)
        $rose(sns_sclk) |-> $stable(sns_mosi)); // R3
    AST_BUSY_DONE_EXCL: assert property (@(posedge hst_clk) disable iff (!hst_rst_n)
        st_busy |-> !st_done); // R5
    AST_REJ_STICKY: assert property (@(posedge hst_clk) disable iff (!hst_rst_n)
        (st_rej && !clr_rej) |=> st_rej); // R6
endmodule

bind sreg_spi_engine sreg_spi_engine_chk #(
    .REG_BITS(REG_BITS), .HOST_W(HOST_W), .ADDR_W(ADDR_W)
) u_chk (
    .hst_clk(hst_clk), .hst_rst_n(hst_rst_n), .hst_wr(hst_wr),
    .hst_addr(hst_addr), .hst_wdata(hst_wdata),
    .sns_clk(sns_clk), .sns_rst_n(sns_rst_n), .sns_sclk(sns_sclk),
    .sns_csn(sns_csn), .sns_mosi(sns_mosi),
    .st_busy(st_busy), .st_done(st_done), .st_rej(st_rej)
);

// File: tb/sreg_spi_engine_bench.sv
`timescale 1ns/1ps
module sreg_spi_engine_bench;
    logic        hst_clk = 1'b0, sns_clk = 1'b0;
    logic        hst_rst_n = 1'b0, sns_rst_n = 1'b0;
    logic        hst_wr = 1'b0, hst_rd = 1'b0;
    logic [3:0]  hst_addr = '0;
    logic [31:0] hst_wdata = '0;
    logic [31:0] hst_rdata;
    logic        sns_sclk, sns_csn, sns_mosi, sns_miso;

    int n_chk = 0, n_err = 0;
    bit finished = 1'b0;

    logic [7:0] s_img [32];
    logic       s_seen [256];
    int         s_rises = 0;
    logic [7:0] e_tx [32];
    logic [31:0] rd_v;

    always #4  hst_clk = ~hst_clk;
    always #20 sns_clk = ~sns_clk;

    sreg_spi_engine u_sreg_spi_engine (
        .hst_clk(hst_clk), .hst_rst_n(hst_rst_n), .hst_wr(hst_wr), .hst_rd(hst_rd),
        .hst_addr(hst_addr), .hst_wdata(hst_wdata), .hst_rdata(hst_rdata),
        .sns_clk(sns_clk), .sns_rst_n(sns_rst_n), .sns_sclk(sns_sclk),
        .sns_csn(sns_csn), .sns_mosi(sns_mosi), .sns_miso(sns_miso)
    );

    // sensor slave model: records MOSI on rising SCLK, serves its image on MISO
    always @(negedge sns_csn or posedge sns_sclk) begin
        if (!sns_csn && sns_sclk) begin
            if (s_rises < 256) s_seen[s_rises] = sns_mosi;
            s_rises = s_rises + 1;
        end else if (!sns_csn) begin
            s_rises = 0;
        end
    end

    function automatic logic img_bit(int i);
        if (i < 0 || i > 255) return 1'b0;
        return s_img[i / 8][7 - (i % 8)];
    endfunction

    assign sns_miso = sns_csn ? 1'b0 : img_bit(sns_sclk ? s_rises - 1 : s_rises);

    task automatic check(bit ok, string what, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s: actual %0h expected %0h", what, act, exp);
        end
    endtask

    task automatic hwrite(logic [3:0] a, logic [31:0] v);
        @(negedge hst_clk);
        hst_wr = 1'b1; hst_addr = a; hst_wdata = v;
        @(negedge hst_clk);
        hst_wr = 1'b0;
    endtask

    task automatic hread(logic [3:0] a, output logic [31:0] v);
        @(negedge hst_clk);
        hst_rd = 1'b1; hst_addr = a;
        @(negedge hst_clk);
        hst_rd = 1'b0;
        v = hst_rdata;
    endtask

    task automatic wait_idle();
        logic [31:0] s;
        for (int k = 0; k < 20000; k++) begin
            hread(4'd8, s);
            if (!s[0]) return;
        end
    endtask

    task automatic load_tx(int seed);
        for (int b = 0; b < 32; b++) e_tx[b] = 8'((b * 37 + seed * 11 + 5) ^ (seed << 3));
        for (int w = 0; w < 8; w++)
            hwrite(4'(w), {e_tx[4*w+3], e_tx[4*w+2], e_tx[4*w+1], e_tx[4*w]});
    endtask

    function automatic int seen_mismatch();
        int m = 0;
        for (int i = 0; i < 256; i++)
            if (s_seen[i] !== e_tx[i / 8][7 - (i % 8)]) m++;
        return m;
    endfunction

    task automatic t_reset();
        hread(4'd8, rd_v);
        check(rd_v == 32'h0, "R1 status after reset", rd_v, 32'h0);
        check(sns_csn === 1'b1 && sns_sclk === 1'b0 && sns_mosi === 1'b0,
              "R1 idle SPI pins", {29'b0, sns_csn, sns_sclk, sns_mosi}, 32'h4);
        hread(4'd12, rd_v);
        check(rd_v == 32'h0, "R9 unmapped address 12", rd_v, 32'h0);
        hread(4'd9, rd_v);
        check(rd_v == 32'h0, "R9 unmapped address 9", rd_v, 32'h0);
    endtask

    task automatic t_write_burst(int seed);
        load_tx(seed);
        hwrite(4'd8, 32'h1);
        hread(4'd8, rd_v);
        check(rd_v == 32'h1, "R5 busy set and done cleared on start", rd_v, 32'h1);
        wait_idle();
        hread(4'd8, rd_v);
        check(rd_v == 32'h2, "R5 done after write burst", rd_v, 32'h2);
        check(s_rises == 256, "R2 SCLK edges in write burst", 32'(s_rises), 32'd256);
        check(seen_mismatch() == 0, "R3 write byte and bit order", 32'(seen_mismatch()), 32'h0);
    endtask

    task automatic t_read_burst(int seed);
        int bad = 0;
        for (int b = 0; b < 32; b++) s_img[b] = 8'((b * 53 + seed * 29 + 1) ^ 8'hA5);
        hwrite(4'd8, 32'h2);
        wait_idle();
        check(s_rises == 256, "R2 SCLK edges in read burst", 32'(s_rises), 32'd256);
        for (int i = 0; i < 256; i++) if (s_seen[i] !== 1'b0) bad++;
        check(bad == 0, "R4 MOSI low during read", 32'(bad), 32'h0);
        for (int w = 0; w < 8; w++) begin
            logic [31:0] exp;
            exp = {s_img[4*w+3], s_img[4*w+2], s_img[4*w+1], s_img[4*w]};
            hread(4'(w), rd_v);
            check(rd_v == exp, "R4 captured word", rd_v, exp);
        end
    endtask

    task automatic t_reject();
        logic [31:0] w0_before;
        hread(4'd0, w0_before);
        load_tx(7);
        hwrite(4'd8, 32'h1);
        hwrite(4'd8, 32'h2);
        hread(4'd8, rd_v);
        check(rd_v == 32'h5, "R6 rejected set while busy", rd_v, 32'h5);
        wait_idle();
        hread(4'd8, rd_v);
        check(rd_v == 32'h6, "R6 rejected sticky after burst", rd_v, 32'h6);
        check(seen_mismatch() == 0, "R6 running write burst not disturbed", 32'(seen_mismatch()), 32'h0);
        hread(4'd0, rd_v);
        check(rd_v == w0_before, "R6 ignored read request left capture buffer", rd_v, w0_before);
        hwrite(4'd8, 32'h4);
        hread(4'd8, rd_v);
        check(rd_v == 32'h2, "R6 rejected cleared by writing bit 2", rd_v, 32'h2);
    endtask

    task automatic t_buf_write_busy();
        load_tx(3);
        hwrite(4'd8, 32'h1);
        hwrite(4'd0, 32'hDEADBEEF);
        hwrite(4'd5, 32'h0BADF00D);
        wait_idle();
        check(seen_mismatch() == 0, "R8 buffer write while busy ignored (this burst)", 32'(seen_mismatch()), 32'h0);
        hwrite(4'd8, 32'h1);
        wait_idle();
        check(seen_mismatch() == 0, "R8 stored image unchanged (next burst)", 32'(seen_mismatch()), 32'h0);
    endtask

    task automatic t_both_bits();
        load_tx(9);
        hwrite(4'd8, 32'h3);
        wait_idle();
        check(s_rises == 256, "R7 both bits start one burst", 32'(s_rises), 32'd256);
        check(seen_mismatch() == 0, "R7 both bits give write burst", 32'(seen_mismatch()), 32'h0);
    endtask

    initial begin
        for (int b = 0; b < 32; b++) s_img[b] = 8'h00;
        repeat (4) @(posedge sns_clk);
        @(negedge hst_clk);
        hst_rst_n = 1'b1; sns_rst_n = 1'b1;
        repeat (4) @(posedge hst_clk);
        t_reset();
        t_write_burst(1);
        t_read_burst(2);
        t_write_burst(4);
        t_reject();
        t_buf_write_busy();
        t_read_burst(5);
        t_both_bits();
        finished = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end

    initial begin
        repeat (190000) @(posedge hst_clk);
        if (!finished) begin
            n_chk++;
            n_err++;
            $display("FAIL watchdog: run did not complete");
            $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
            $finish;
        end
    end
endmodule